// File: doc/BRIEF.md
# Threshold-Driven Data Buffer with DMA Requests

This block is a circular buffer of 16-bit words that sits between a host register port and a card-side transfer engine. Either side can push words in or pop them out, one word per cycle. The current head word is always visible on one output. The fill count is visible on another output, so the transfer engine can pace itself.

A configuration word holds two programmable levels, a high-water mark and a low-water mark, and a DMA enable for each direction. After each change of state, the block compares the fill count against the level that matters for the current transfer direction. When the level is crossed, the block does one of two things, chosen by that direction's DMA enable. It raises a DMA request line, or it raises a polled status flag that software can read. Both outputs are levels, not pulses.

A start input begins a new transfer. It empties the buffer and returns both indices to slot zero.

Top module: `dma_thresh_fifo`

## Requirements
- R1: After reset, `cfg_rdata` reads 16'h1F00: the high-water level is 31, the low-water level is 0 and both DMA enables are 0. `fill` is 0, and both flags and both requests are low.
- R2: The configuration word has four fields. The receive DMA enable is bit 15 and the high-water level is bits 12:8. The transmit DMA enable is bit 7 and the low-water level is bits 4:0. All other bits read back as 0, so writing 16'hFFFF reads back 16'h9F9F.
- R3: Words leave in the order they entered. The head and tail indices wrap modulo 32, and `head_word` always shows the word at the head index.
- R4: A push while 32 words are held is discarded. It changes neither `fill` nor the stored data.
- R5: A pop while empty leaves `fill` at 0 and leaves the indices unchanged. `head_word` keeps showing the word at the head slot.
- R6: When `xfer_dir`=1 (card to host) and `fill` is strictly greater than the high-water level, the block reacts as follows. It raises `dma_rx_req` if receive DMA is enabled; otherwise it raises `flag_rx_level`. In every other case both of these signals are low.
- R7: When `xfer_dir`=0 (host to card) and `fill` is strictly less than the low-water level, the block reacts as follows. It raises `dma_tx_req` if transmit DMA is enabled; otherwise it raises `flag_tx_level`. In every other case both of these signals are low.
- R8: When `xfer_active`=0 and the buffer is empty, an evaluation clears both flags and leaves the DMA requests as they were.
- R9: A configuration write with a DMA enable bit set clears that direction's flag at the same clock edge as the write, one cycle before the levels are re-evaluated.
- R10: Flags and requests are re-evaluated one cycle after any push, pop, configuration write or start. Between evaluations they hold their value.
- R11: A pulse on `xfer_start` sets `fill` to 0 and both indices to slot 0.
- R12: When a push and a pop fall in the same cycle, the outcome depends on the fill count. If full, only the pop takes effect. If empty, only the push takes effect. Otherwise both take effect and `fill` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Begin a new transfer; empties the buffer |
| xfer_active | input | 1 | A transfer is in progress |
| xfer_dir | input | 1 | 1 = card to host, 0 = host to card |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback |
| host_push | input | 1 | Host data-register write |
| host_wdata | input | 16 | Host write word |
| host_pop | input | 1 | Host data-register read |
| card_push | input | 1 | Card-side push |
| card_wdata | input | 16 | Card-side write word |
| card_pop | input | 1 | Card-side pop |
| head_word | output | 16 | Word at the head index |
| fill | output | 6 | Number of words held |
| flag_rx_level | output | 1 | Polled receive-level flag |
| flag_tx_level | output | 1 | Polled transmit-level flag |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
A push and a pop can land in the same cycle. At the full and empty boundaries, this case decides whether the over-run and under-run guards act on each port alone. The bench drives a host push and a card pop on the same edge in three states: with 32 words held, with the buffer empty and with a partial fill. It then judges `fill` and `head_word` against the expected winner. In the full case it also confirms that the discarded word never reaches the head.

// File: rtl/dma_thresh_fifo.sv
module dma_thresh_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic             xfer_active,
  input  logic             xfer_dir,
  input  logic             cfg_we,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic             host_push,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             host_pop,
  input  logic             card_push,
  input  logic [WIDTH-1:0] card_wdata,
  input  logic             card_pop,
  output logic [WIDTH-1:0] head_word,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic             flag_rx_level,
  output logic             flag_tx_level,
  output logic             dma_rx_req,
  output logic             dma_tx_req
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [IDX_W-1:0] head, tail;
  logic [IDX_W-1:0] hi_lvl, lo_lvl;
  logic             rx_dma_en, tx_dma_en;
  logic             dirty;

  wire push_req = host_push | card_push;
  wire pop_req  = host_pop  | card_pop;
  wire do_push  = push_req && (fill != CNT_W'(DEPTH));
  wire do_pop   = pop_req  && (fill != '0);
  wire [WIDTH-1:0] wr_word = host_push ? host_wdata : card_wdata;

  wire rx_hit = xfer_dir  && (fill > CNT_W'(hi_lvl));
  wire tx_hit = !xfer_dir && (fill < CNT_W'(lo_lvl));
  wire idle_empty = !xfer_active && (fill == '0);

  assign head_word = mem[head];
  assign cfg_rdata = {rx_dma_en, 2'b00, 5'(hi_lvl), tx_dma_en, 2'b00, 5'(lo_lvl)};

  always_ff @(posedge clk) begin
    if (do_push && !xfer_start) mem[tail] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      fill <= '0;
    end else if (xfer_start) begin
      head <= '0;
      tail <= '0;
      fill <= '0;
    end else begin
      if (do_push) tail <= tail + 1'b1;
      if (do_pop)  head <= head + 1'b1;
      if (do_push && !do_pop)      fill <= fill + 1'b1;
      else if (do_pop && !do_push) fill <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_dma_en <= 1'b0;
      tx_dma_en <= 1'b0;
      hi_lvl    <= '1;
      lo_lvl    <= '0;
    end else if (cfg_we) begin
      rx_dma_en <= cfg_wdata[15];
      hi_lvl    <= cfg_wdata[8 +: IDX_W];
      tx_dma_en <= cfg_wdata[7];
      lo_lvl    <= cfg_wdata[0 +: IDX_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirty <= 1'b0;
    else        dirty <= push_req | pop_req | cfg_we | xfer_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_rx_level <= 1'b0;
      flag_tx_level <= 1'b0;
      dma_rx_req    <= 1'b0;
      dma_tx_req    <= 1'b0;
    end else begin
      if (dirty) begin
        if (idle_empty) begin
          flag_rx_level <= 1'b0;
          flag_tx_level <= 1'b0;
        end else begin
          dma_rx_req    <= rx_hit &&  rx_dma_en;
          flag_rx_level <= rx_hit && !rx_dma_en;
          dma_tx_req    <= tx_hit &&  tx_dma_en;
          flag_tx_level <= tx_hit && !tx_dma_en;
        end
      end
      if (cfg_we && cfg_wdata[15]) flag_rx_level <= 1'b0;
      if (cfg_we && cfg_wdata[7])  flag_tx_level <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_thresh_fifo_chk.sv
module dma_thresh_fifo_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             push,
  input logic             pop,
  input logic             cfg_we,
  input logic [15:0]      cfg_wdata,
  input logic [CNT_W-1:0] fill,
  input logic             flag_rx,
  input logic             flag_tx,
  input logic             dma_rx,
  input logic             dma_tx
);
  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CNT_W'(DEPTH) && push && !pop && !start) |=> fill == CNT_W'(DEPTH));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0 && pop && !push && !start) |=> fill == '0);

  assert_rx_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_rx && dma_rx));

  assert_tx_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_tx && dma_tx));

  assert_rx_cfg_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[15]) |=> !flag_rx);

  assert_tx_cfg_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[7]) |=> !flag_tx);

  assert_one_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_rx, dma_tx}));

  assert_start_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> fill == '0);

  assert_both_mid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != '0 && fill != CNT_W'(DEPTH) && push && pop && !start) |=> $stable(fill));
endmodule

bind dma_thresh_fifo dma_thresh_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(xfer_start),
  .push(host_push | card_push), .pop(host_pop | card_pop),
  .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .fill(fill),
  .flag_rx(flag_rx_level), .flag_tx(flag_tx_level),
  .dma_rx(dma_rx_req), .dma_tx(dma_tx_req)
);

// File: tb/dma_thresh_fifo_tb.sv
module dma_thresh_fifo_tb_top;
  logic clk = 0, rst_n = 0;
  logic xfer_start = 0, xfer_active = 0, xfer_dir = 0;
  logic cfg_we = 0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic host_push = 0, host_pop = 0, card_push = 0, card_pop = 0;
  logic [15:0] host_wdata = '0, card_wdata = '0, head_word;
  logic [5:0] fill;
  logic flag_rx_level, flag_tx_level, dma_rx_req, dma_tx_req;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_thresh_fifo dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cfg(logic [15:0] v);
    cfg_we = 1; cfg_wdata = v; tick(); cfg_we = 0;
  endtask

  task automatic hpush(logic [15:0] v);
    host_push = 1; host_wdata = v; tick(); host_push = 0;
  endtask

  task automatic cpush(logic [15:0] v);
    card_push = 1; card_wdata = v; tick(); card_push = 0;
  endtask

  task automatic cpop();
    card_pop = 1; tick(); card_pop = 0;
  endtask

  task automatic hpop();
    host_pop = 1; tick(); host_pop = 0;
  endtask

  task automatic start_xfer(logic act, logic dir);
    xfer_active = act; xfer_dir = dir; xfer_start = 1; tick(); xfer_start = 0;
  endtask

  task automatic t_reset();
    chk("R1 cfg", cfg_rdata, 16'h1F00);
    chk("R1 fill", fill, 0);
    chk("R1 outs", {flag_rx_level, flag_tx_level, dma_rx_req, dma_tx_req}, 0);
  endtask

  task automatic t_order_bounds();
    start_xfer(0, 0);
    for (int i = 0; i < 33; i++) hpush(16'h0100 + 16'(i * 3));
    chk("R4 fill full", fill, 32);
    for (int i = 0; i < 32; i++) begin
      chk("R3 order", head_word, 16'h0100 + 16'(i * 3));
      cpop();
    end
    chk("R3 drained", fill, 0);
    chk("R4 wrap head slot0", head_word, 16'h0100);
    hpop();
    chk("R5 fill", fill, 0);
    chk("R5 head word", head_word, 16'h0100);
  endtask

  task automatic t_rx();
    start_xfer(1, 1);
    cfg(16'h0300);
    chk("R2 readback", cfg_rdata, 16'h0300);
    for (int i = 0; i < 3; i++) cpush(16'hA000 + 16'(i));
    tick();
    chk("R6 at level", {flag_rx_level, dma_rx_req}, 0);
    cpush(16'hA003);
    chk("R10 not yet", flag_rx_level, 0);
    tick();
    chk("R6 flag", {flag_rx_level, dma_rx_req}, 2'b10);
    cfg(16'h8300);
    chk("R9 flag cleared at write", flag_rx_level, 0);
    chk("R9 req not yet", dma_rx_req, 0);
    tick();
    chk("R6 dma", {flag_rx_level, dma_rx_req}, 2'b01);
    hpop();
    tick();
    chk("R6 below", {flag_rx_level, dma_rx_req}, 0);
    cpush(16'hA004);
    tick();
    repeat (5) tick();
    chk("R10 level held", dma_rx_req, 1);
    cfg(16'hFFFF);
    chk("R2 reserved zero", cfg_rdata, 16'h9F9F);
  endtask

  task automatic t_tx();
    start_xfer(1, 0);
    cfg(16'h1F02);
    tick();
    chk("R7 flag empty", {flag_tx_level, dma_tx_req}, 2'b10);
    hpush(16'hB000);
    tick();
    chk("R7 flag one", flag_tx_level, 1);
    hpush(16'hB001);
    tick();
    chk("R7 at level", {flag_tx_level, dma_tx_req}, 0);
    cfg(16'h1F82);
    tick();
    chk("R7 dma off at level", dma_tx_req, 0);
    cpop();
    tick();
    chk("R7 dma", {flag_tx_level, dma_tx_req}, 2'b01);
  endtask

  task automatic t_idle();
    cfg(16'h1F02);
    tick();
    chk("R7 flag again", {flag_tx_level, dma_tx_req}, 2'b10);
    xfer_active = 0;
    hpop();
    tick();
    chk("R8 idle empty", {flag_rx_level, flag_tx_level}, 0);
  endtask

  task automatic t_start();
    for (int i = 0; i < 3; i++) hpush(16'hC000 + 16'(i));
    chk("R11 pre", fill, 3);
    start_xfer(0, 0);
    chk("R11 emptied", fill, 0);
    hpush(16'hBEEF);
    chk("R11 head reset", head_word, 16'hBEEF);
  endtask

  task automatic t_same();
    start_xfer(0, 0);
    for (int i = 0; i < 32; i++) hpush(16'h2000 + 16'(i));
    host_push = 1; host_wdata = 16'h5555; card_pop = 1; tick();
    host_push = 0; card_pop = 0;
    chk("R12 full fill", fill, 31);
    chk("R12 full head", head_word, 16'h2001);
    start_xfer(0, 0);
    host_push = 1; host_wdata = 16'h7777; card_pop = 1; tick();
    host_push = 0; card_pop = 0;
    chk("R12 empty fill", fill, 1);
    chk("R12 empty head", head_word, 16'h7777);
    for (int i = 1; i < 5; i++) hpush(16'h7000 + 16'(i));
    host_push = 1; host_wdata = 16'h7005; card_pop = 1; tick();
    host_push = 0; card_pop = 0;
    chk("R12 mid fill", fill, 5);
    chk("R12 mid head", head_word, 16'h7001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order_bounds();
    t_rx();
    t_tx();
    t_idle();
    t_start();
    t_same();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule